// File: doc/BRIEF.md
# One-Hot Serial 1011 Pattern Detector

This block watches a one-bit serial stream and raises a one-cycle flag after the bits 1, 0, 1, 1 have arrived in that order. One input bit is taken on every rising clock edge. There is no valid/ready pair on this link: the detector accepts a bit on every cycle and never applies back-pressure. An upstream source with gaps in its stream has to hold the clock enable or gate the stream itself.

Matches may overlap. After a match the machine moves to the partial-match state that the trailing bits of that match imply. A new match can therefore reuse those bits, so a stream of 1011011 yields two flags.

The controller is a Moore machine with five states. Each state has its own flip-flop. The detect output is the flip-flop of the matched state, so it changes only at clock edges.

The five-bit state vector is also driven to a port for checking. Its bit positions are:

- bit 0: idle
- bit 1: seen "1"
- bit 2: seen "10"
- bit 3: seen "101"
- bit 4: matched

Top module: `seq1011_detector`

## Requirements
- R1: While `rst_n` is low, `state_vec` is 5'b00001 (only the idle bit set) and `detect` is 0, without waiting for a clock edge.
- R2: Out of reset, exactly one bit of `state_vec` is set at every clock edge.
- R3: `detect` always equals `state_vec[4]`, the matched-state bit.
- R4: `detect` is 1 in exactly the cycle that follows the rising edge at which the final 1 of a 1011 run is sampled. It is 0 in all other cycles. Two matches can never complete on adjacent edges, so `detect` is a single-cycle pulse.
- R5: Transitions before a match, with bit positions as listed above:
  - from idle, 0 stays in idle and 1 goes to seen "1";
  - from seen "1", 0 goes to seen "10" and 1 stays;
  - from seen "10", 0 goes to idle and 1 goes to seen "101";
  - from seen "101", 0 goes to seen "10" and 1 goes to matched.
- R6: From matched, 1 goes to seen "1" and 0 goes to seen "10". As a result, the streams 1011011 and 10111011 each raise `detect` twice.
- R7: A stream that holds no 1011 run never raises `detect`. Examples are all zeros, all ones and repeats of 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The serial bit is sampled on the rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. It presets the idle state. |
| serial_in | input | 1 | Serial data bit, taken on every cycle. |
| detect | output | 1 | Moore flag that is high for the cycle after a 1011 match. |
| state_vec | output | 5 | One-hot state, with bit positions as in R5. |

## Verification
The hardest paths to reach from the ports are the exits from the matched state, because they need a full match followed by the right next bit. They must also be reached with history still present in the stream, not straight after reset.

The bench resets and then drives every possible 10-bit stream. This passes through the matched state with both input values, from every prefix. The expected state is computed each cycle as the longest suffix of the bits so far that is also a prefix of 1011.

Directed overlap streams cover the double-match cases. A reset applied in the middle of a partial match checks that the preset acts without a clock edge.

// File: rtl/seq1011_pkg.sv
package seq1011_pkg;

  localparam int NUM_STATES = 5;
  localparam int PAT_LEN    = NUM_STATES - 1;

  localparam int IDX_IDLE   = 0;
  localparam int IDX_SEEN1  = 1;
  localparam int IDX_SEEN10 = 2;
  localparam int IDX_SEEN101 = 3;
  localparam int IDX_MATCH  = 4;

  typedef logic [NUM_STATES-1:0] state_vec_t;

  localparam state_vec_t IDLE_VEC = state_vec_t'(1) << IDX_IDLE;

endpackage

// File: rtl/seq1011_next_state.sv
module seq1011_next_state
  import seq1011_pkg::*;
(
  input  state_vec_t cur_state,
  input  logic       bit_in,
  output state_vec_t nxt_state
);

  logic bit_n;
  assign bit_n = ~bit_in;

  // Each term is the single active-state bit ANDed with the input or its complement.
  always_comb begin
    nxt_state              = '0;
    nxt_state[IDX_IDLE]    = (cur_state[IDX_IDLE]   & bit_n)
                           | (cur_state[IDX_SEEN10] & bit_n);
    nxt_state[IDX_SEEN1]   = (cur_state[IDX_IDLE]   & bit_in)
                           | (cur_state[IDX_SEEN1]  & bit_in)
                           | (cur_state[IDX_MATCH]  & bit_in);
    nxt_state[IDX_SEEN10]  = (cur_state[IDX_SEEN1]   & bit_n)
                           | (cur_state[IDX_SEEN101] & bit_n)
                           | (cur_state[IDX_MATCH]   & bit_n);
    nxt_state[IDX_SEEN101] = cur_state[IDX_SEEN10]  & bit_in;
    nxt_state[IDX_MATCH]   = cur_state[IDX_SEEN101] & bit_in;
  end

endmodule

// File: rtl/seq1011_state_reg.sv
module seq1011_state_reg #(
  parameter int               WIDTH     = 5,
  parameter logic [WIDTH-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (RESET_VEC[i]) begin : g_preset
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b1;
        else        q[i] <= d[i];
      end
    end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= d[i];
      end
    end
  end

endmodule

// File: rtl/seq1011_detector.sv
module seq1011_detector
  import seq1011_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  serial_in,
  output logic                  detect,
  output logic [NUM_STATES-1:0] state_vec
);

  state_vec_t state_q;
  state_vec_t state_d;

  seq1011_next_state u_next (
    .cur_state (state_q),
    .bit_in    (serial_in),
    .nxt_state (state_d)
  );

  seq1011_state_reg #(
    .WIDTH     (NUM_STATES),
    .RESET_VEC (IDLE_VEC)
  ) u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (state_d),
    .q     (state_q)
  );

  assign detect    = state_q[IDX_MATCH];
  assign state_vec = state_q;

  AST_STATE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1); // R2

  AST_MATCH_AFTER_101_1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[IDX_SEEN101] && serial_in |=> detect); // R4

  AST_DETECT_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect); // R4

  AST_SEEN10_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[IDX_SEEN10] && !serial_in |=> state_vec[IDX_IDLE]); // R5

  AST_MATCH_ONE_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    detect && serial_in |=> state_vec[IDX_SEEN1]); // R6

  AST_MATCH_ZERO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    detect && !serial_in |=> state_vec[IDX_SEEN10]); // R6

endmodule

// File: tb/seq1011_detector_bench.sv
module seq1011_detector_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_in = 1'b0;
  logic       detect;
  logic [4:0] state_vec;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] hist = '0;
  int   nbits = 0;
  int   pulses = 0;

  seq1011_detector u_seq1011_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .serial_in (serial_in),
    .detect    (detect),
    .state_vec (state_vec)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_detect();
    return (nbits >= 4) && (hist[3:0] == 4'b1011);
  endfunction

  function automatic logic [4:0] exp_state();
    if (exp_detect())                          return 5'b10000;
    if (nbits >= 3 && hist[2:0] == 3'b101)     return 5'b01000;
    if (nbits >= 2 && hist[1:0] == 2'b10)      return 5'b00100;
    if (nbits >= 1 && hist[0])                 return 5'b00010;
    return 5'b00001;
  endfunction

  // Called at a falling edge; assert reset asynchronously and check before any clock edge.
  task automatic do_reset();
    #2 rst_n = 1'b0;
    #3;
    chk("R1 async state", state_vec, 5'b00001);
    chk("R1 detect", detect, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    hist = '0;
    nbits = 0;
  endtask

  // Called at a falling edge; ends at the next falling edge after checking.
  task automatic step(input logic b);
    serial_in = b;
    @(posedge clk);
    hist = {hist[30:0], b};
    nbits++;
    @(negedge clk);
    if (detect) pulses++;
    chk("R4 detect", detect, exp_detect());
    chk("R5 state", state_vec, exp_state());
    chk("R3 detect=bit4", detect, state_vec[4]);
    chk("R2 one-hot", $countones(state_vec), 1);
  endtask

  task automatic run_seq(input logic [31:0] bits, input int len);
    do_reset();
    pulses = 0;
    for (int i = len - 1; i >= 0; i--) step(bits[i]);
  endtask

  initial begin
    #3_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 state after release", state_vec, 5'b00001);

    // R6 overlap cases
    run_seq(32'b1011011, 7);
    chk("R6 1011011 pulses", pulses, 2);
    run_seq(32'b10111011, 8);
    chk("R6 10111011 pulses", pulses, 2);

    // R7 streams with no 1011 run
    run_seq(32'h0, 12);
    chk("R7 zeros pulses", pulses, 0);
    run_seq(32'hFFF, 12);
    chk("R7 ones pulses", pulses, 0);
    run_seq(32'b100100100100, 12);
    chk("R7 100 repeat pulses", pulses, 0);

    // R1 reset in the middle of a partial match
    run_seq(32'b101, 3);
    chk("R1 pre-reset seen101", state_vec, 5'b01000);
    do_reset();
    step(1'b1);

    // Sweep of every 10-bit stream from reset (R4, R5, R6)
    for (int v = 0; v < 1024; v++) run_seq(32'(v), 10);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule